// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Down Controller

This block owns the clock-enable line of an SDRAM array. It puts the memory devices into power-down when a power-management request arrives, and brings them back out when the request is withdrawn. Holding clock-enable low stops the devices' internal clock. Raising it again restores normal operation. Clock-enable is never lowered while a bank is open. If any bank is open when the request arrives, the block first asks the command path for a precharge-all and waits for it to finish.

The same pin also carries a configuration strap. The output driver is released from the moment the main reset is asserted until four clocks after CPU reset is released. The level on the pin is latched on the last clock of that window and held until the next reset. An unstrapped pin reads 0 through its weak pull-down. After the window, the block drives clock-enable high and tells the command scheduler when it may issue commands.

Top module: `cke_pwrdn_ctrl`

## Requirements
- R1: While `rst_n` or `cpu_rst_n` is low, and for the first three rising edges after `cpu_rst_n` goes high, `cke_oe` is 0. It becomes 1 after the fourth rising edge.
- R2: `strap_q` takes the level of `cke_i` at the fourth rising edge after `cpu_rst_n` goes high. It stays stable until the next reset. It is 0 after `rst_n` asserts.
- R3: After the fourth window edge, `cke_o` is 1. `cmd_ready` rises one clock later.
- R4: A power-down request (`pd_req`=1) that arrives in normal operation with every `banks_open` bit at 0 lowers `cke_o` at the next edge, without raising `pre_req`.
- R5: A power-down request with any `banks_open` bit set raises `pre_req` at the next edge. `pre_req` holds until an edge that sees `pre_ack`=1. `cke_o` then stays high for `PRE_DLY` more edges (default 3).
- R6: `cke_o` never falls while a `banks_open` bit is set. If a bank is open at the end of the precharge delay, the block asks for precharge again and keeps `cke_o` high.
- R7: `pd_ack` is 1 exactly while the block drives `cke_o` low.
- R8: When `pd_req` drops during power-down, `cke_o` is 1 after the next edge. `cmd_ready` then stays 0 for `exit_clks` clocks. If `exit_clks` is 0, `cmd_ready` is 1 at once.
- R9: `cmd_ready` is 0 throughout precharge, the precharge delay, power-down and the exit delay. If `pd_req` drops during the precharge delay, the block returns to normal operation without lowering `cke_o`.
- R10: `cpu_rst_n` going low in any state drops `cke_oe`, `pd_ack` and `cmd_ready` at the next edge and reopens the strap window. The strap is then sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main reset, active low, asynchronous |
| cpu_rst_n | input | 1 | CPU reset, active low, sampled on the clock |
| pd_req | input | 1 | Power-down request; level held while power-down is wanted |
| pd_ack | output | 1 | High while the SDRAM is held in power-down |
| banks_open | input | NUM_BANKS | One bit per bank, 1 = bank open |
| pre_req | output | 1 | Precharge-all request to the command path |
| pre_ack | input | 1 | Precharge-all accepted |
| exit_clks | input | EXIT_W | Clocks to withhold commands after leaving power-down |
| cke_o | output | 1 | Clock-enable output level |
| cke_oe | output | 1 | Clock-enable output driver enable |
| cke_i | input | 1 | Level read back from the clock-enable pin |
| strap_q | output | 1 | Latched strap value |
| cmd_ready | output | 1 | The scheduler may issue SDRAM commands |

## Verification
A power-down request is tried in three forms: with all banks closed, with a bank open and a late precharge acknowledge, and with a bank still open when the precharge delay ends. These separate the direct path, the precharge handshake and the re-precharge guard. The request is also withdrawn during the precharge delay, to show that clock-enable never drops in that case. The exit is run with a non-zero and with a zero exit count. The strap is driven high, and also high with a low level only at the final window edge, which pins down the exact edge where it is latched. CPU reset is asserted during power-down to show the return to the window and a fresh strap.

// File: rtl/cke_pkg.sv
package cke_pkg;

   typedef enum logic [2:0] {
      ST_STRAP    = 3'd0,
      ST_RUN      = 3'd1,
      ST_PRE_REQ  = 3'd2,
      ST_PRE_WAIT = 3'd3,
      ST_PD       = 3'd4,
      ST_EXIT     = 3'd5
   } cke_state_e;

   // Number of clocks after CPU reset release that the pin stays an input.
   localparam int unsigned STRAP_WIN = 4;

endpackage

// File: rtl/cke_dcount.sv
module cke_dcount #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt_o,
   output logic         last_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("cke_dcount: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == W'(1));

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q == '0) |=> cnt_q == '0);   // R8

endmodule

// File: rtl/cke_strap_window.sv
module cke_strap_window #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_rst_n,
   input  logic pin_i,
   output logic win_open_o,
   output logic drive_en_o,
   output logic strap_o
);
   import cke_pkg::*;

   localparam int unsigned CW = $clog2(STRAP_WIN + 1);

   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("cke_strap_window: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic pin_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], pin_i};
         end
         assign pin_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic          strap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         done_q  <= 1'b0;
         strap_q <= 1'b0;
      end else if (!cpu_rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == CW'(STRAP_WIN - 1)) begin
            done_q  <= 1'b1;
            strap_q <= pin_s;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign win_open_o = !cpu_rst_n || !done_q;
   assign drive_en_o = done_q;
   assign strap_o    = strap_q;

   AST_OE_OFF_CPU_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rst_n |=> !drive_en_o);   // R1
   AST_STRAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && $past(done_q)) |-> $stable(strap_q));   // R2

endmodule

// File: rtl/cke_pd_fsm.sv
module cke_pd_fsm #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned PRE_DLY   = 3,
   parameter int unsigned EXIT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_open,
   input  logic              pd_req,
   input  logic [NUM_BANKS-1:0] banks_open,
   input  logic              pre_ack,
   input  logic [EXIT_W-1:0] exit_clks,
   output logic              pre_req,
   output logic              cke_drive,
   output logic              in_pd,
   output logic              in_run
);
   import cke_pkg::*;

   localparam int unsigned PW = $clog2(PRE_DLY + 1);

   generate
      if (PRE_DLY < 1) begin : g_bad_dly
         $error("cke_pd_fsm: PRE_DLY must be at least 1");
      end
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("cke_pd_fsm: NUM_BANKS must be at least 1");
      end
   endgenerate

   cke_state_e state_q, state_d;
   logic       any_open;
   logic       pre_load, pre_dec, pre_last;
   logic       ex_load, ex_dec, ex_last;
   logic [PW-1:0]     pre_cnt;
   logic [EXIT_W-1:0] ex_cnt;

   assign any_open = |banks_open;

   always_comb begin
      state_d  = state_q;
      pre_load = 1'b0;
      pre_dec  = 1'b0;
      ex_load  = 1'b0;
      ex_dec   = 1'b0;
      unique case (state_q)
         ST_STRAP: begin
            state_d = ST_RUN;
         end
         ST_RUN: begin
            if (pd_req) state_d = any_open ? ST_PRE_REQ : ST_PD;
         end
         ST_PRE_REQ: begin
            if (pre_ack) begin
               state_d  = ST_PRE_WAIT;
               pre_load = 1'b1;
            end
         end
         ST_PRE_WAIT: begin
            if (pre_last) begin
               if (!pd_req)      state_d = ST_RUN;
               else if (any_open) state_d = ST_PRE_REQ;
               else              state_d = ST_PD;
            end else begin
               pre_dec = 1'b1;
            end
         end
         ST_PD: begin
            if (!pd_req) begin
               if (exit_clks == '0) begin
                  state_d = ST_RUN;
               end else begin
                  state_d = ST_EXIT;
                  ex_load = 1'b1;
               end
            end
         end
         ST_EXIT: begin
            if (ex_last) state_d = ST_RUN;
            else         ex_dec  = 1'b1;
         end
         default: state_d = ST_STRAP;
      endcase
      if (win_open) state_d = ST_STRAP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_STRAP;
      else        state_q <= state_d;
   end

   cke_dcount #(.W(PW)) u_pre_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pre_load),
      .load_val (PW'(PRE_DLY)),
      .dec      (pre_dec),
      .cnt_o    (pre_cnt),
      .last_o   (pre_last)
   );

   cke_dcount #(.W(EXIT_W)) u_exit_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ex_load),
      .load_val (exit_clks),
      .dec      (ex_dec),
      .cnt_o    (ex_cnt),
      .last_o   (ex_last)
   );

   assign pre_req   = (state_q == ST_PRE_REQ);
   assign cke_drive = (state_q != ST_PD);
   assign in_pd     = (state_q == ST_PD);
   assign in_run    = (state_q == ST_RUN);

   AST_PRE_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req && !pre_ack && !win_open) |=> pre_req);   // R5
   AST_NO_DROP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_pd) |-> ($past(banks_open) == '0));   // R6
   AST_WAIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE_WAIT) |-> (pre_cnt != '0 && pre_cnt <= PW'(PRE_DLY)));   // R5
   AST_EXIT_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXIT) |-> ex_cnt != '0);   // R8

endmodule

// File: rtl/cke_pwrdn_ctrl.sv
module cke_pwrdn_ctrl #(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned PRE_DLY     = 3,
   parameter int unsigned EXIT_W      = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_rst_n,
   input  logic                 pd_req,
   output logic                 pd_ack,
   input  logic [NUM_BANKS-1:0] banks_open,
   output logic                 pre_req,
   input  logic                 pre_ack,
   input  logic [EXIT_W-1:0]    exit_clks,
   output logic                 cke_o,
   output logic                 cke_oe,
   input  logic                 cke_i,
   output logic                 strap_q,
   output logic                 cmd_ready
);

   logic win_open, drive_en, cke_drive, in_pd, in_run;

   cke_strap_window #(.SYNC_STAGES(SYNC_STAGES)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_rst_n  (cpu_rst_n),
      .pin_i      (cke_i),
      .win_open_o (win_open),
      .drive_en_o (drive_en),
      .strap_o    (strap_q)
   );

   cke_pd_fsm #(
      .NUM_BANKS (NUM_BANKS),
      .PRE_DLY   (PRE_DLY),
      .EXIT_W    (EXIT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_open   (win_open),
      .pd_req     (pd_req),
      .banks_open (banks_open),
      .pre_ack    (pre_ack),
      .exit_clks  (exit_clks),
      .pre_req    (pre_req),
      .cke_drive  (cke_drive),
      .in_pd      (in_pd),
      .in_run     (in_run)
   );

   assign cke_oe    = drive_en;
   assign cke_o     = cke_drive;
   assign pd_ack    = in_pd;
   assign cmd_ready = in_run && drive_en;

   AST_ACK_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      pd_ack |-> (cke_oe && !cke_o));   // R7
   AST_LOW_MEANS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_oe && !cke_o) |-> pd_ack);   // R7
   AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (cke_o && cke_oe && !pre_req));   // R9
   AST_EXIT_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pd_ack) && cke_oe && $past(exit_clks) != '0) |-> !cmd_ready);   // R8

endmodule

// File: tb/tb_cke_pwrdn_ctrl.sv
module tb_cke_pwrdn_ctrl;

   localparam int unsigned NB = 4;
   localparam int unsigned PD = 3;
   localparam int unsigned EW = 8;

   logic          clk = 1'b0;
   logic          rst_n, cpu_rst_n, pd_req, pre_ack, cke_i;
   logic [NB-1:0] banks_open;
   logic [EW-1:0] exit_clks;
   logic          pd_ack, pre_req, cke_o, cke_oe, strap_q, cmd_ready;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   cke_pwrdn_ctrl #(.NUM_BANKS(NB), .PRE_DLY(PD), .EXIT_W(EW)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_rst_n(cpu_rst_n), .pd_req(pd_req),
      .pd_ack(pd_ack), .banks_open(banks_open), .pre_req(pre_req),
      .pre_ack(pre_ack), .exit_clks(exit_clks), .cke_o(cke_o),
      .cke_oe(cke_oe), .cke_i(cke_i), .strap_q(strap_q), .cmd_ready(cmd_ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // Full reset, window with the given per-edge pin levels (edge 1..4).
   task automatic t_reset_window(input logic [3:0] pin);
      rst_n = 1'b0; cpu_rst_n = 1'b0; pd_req = 1'b0; pre_ack = 1'b0;
      banks_open = '0; exit_clks = '0; cke_i = pin[0];
      tick(); tick();
      chk("R1 oe in reset", cke_oe, 0);
      chk("R2 strap after reset", strap_q, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 oe cpu reset held", cke_oe, 0);
      cpu_rst_n = 1'b1;
      for (int e = 0; e < 4; e++) begin
         cke_i = pin[e];
         tick();
         if (e < 3) chk("R1 oe inside window", cke_oe, 0);
      end
      chk("R1 oe after window", cke_oe, 1);
      chk("R2 strap latched at edge 4", strap_q, pin[3]);
      chk("R3 cke high after window", cke_o, 1);
      chk("R3 ready not yet", cmd_ready, 0);
      cke_i = 1'b0;
      tick();
      chk("R3 ready one clock later", cmd_ready, 1);
      chk("R2 strap held", strap_q, pin[3]);
   endtask

   task automatic t_pd_closed();
      banks_open = '0; pd_req = 1'b1;
      tick();
      chk("R4 cke low next edge", cke_o, 0);
      chk("R4 no precharge", pre_req, 0);
      chk("R7 ack while low", pd_ack, 1);
      chk("R9 ready low in pd", cmd_ready, 0);
   endtask

   task automatic t_exit(input int n);
      exit_clks = EW'(n); pd_req = 1'b0;
      tick();
      chk("R8 cke high after exit edge", cke_o, 1);
      chk("R7 ack off", pd_ack, 0);
      for (int i = 1; i < n; i++) begin
         chk("R8 ready held low", cmd_ready, 0);
         tick();
      end
      if (n > 0) begin
         chk("R8 ready low last exit clock", cmd_ready, 0);
         tick();
      end
      chk("R8 ready restored", cmd_ready, 1);
   endtask

   task automatic t_pd_open();
      banks_open = 4'b0100; pd_req = 1'b1;
      tick();
      chk("R5 pre_req raised", pre_req, 1);
      chk("R9 ready low in precharge", cmd_ready, 0);
      tick();
      chk("R5 pre_req held without ack", pre_req, 1);
      pre_ack = 1'b1;
      tick();
      pre_ack = 1'b0; banks_open = '0;
      chk("R5 pre_req dropped after ack", pre_req, 0);
      for (int i = 1; i < PD; i++) begin
         chk("R5 cke high in delay", cke_o, 1);
         tick();
      end
      chk("R5 cke high last delay clock", cke_o, 1);
      tick();
      chk("R5 cke low after delay", cke_o, 0);
      chk("R7 ack with cke low", pd_ack, 1);
   endtask

   task automatic t_reopen();
      banks_open = 4'b0001; pd_req = 1'b1;
      tick();
      pre_ack = 1'b1;
      tick();
      pre_ack = 1'b0;
      for (int i = 0; i < PD; i++) tick();
      chk("R6 cke kept high with bank open", cke_o, 1);
      chk("R6 precharge asked again", pre_req, 1);
      pre_ack = 1'b1;
      tick();
      pre_ack = 1'b0; banks_open = '0;
      for (int i = 0; i < PD; i++) tick();
      chk("R6 cke low once closed", cke_o, 0);
   endtask

   task automatic t_withdraw();
      banks_open = 4'b1000; pd_req = 1'b1;
      tick();
      pre_ack = 1'b1;
      tick();
      pre_ack = 1'b0; banks_open = '0; pd_req = 1'b0;
      for (int i = 0; i < PD; i++) begin
         chk("R9 cke never low on withdraw", cke_o, 1);
         tick();
      end
      chk("R9 back to run", cmd_ready, 1);
      chk("R9 no ack", pd_ack, 0);
   endtask

   task automatic t_cpu_reset_in_pd();
      pd_req = 1'b1; banks_open = '0;
      tick();
      chk("R10 setup pd", pd_ack, 1);
      cpu_rst_n = 1'b0; pd_req = 1'b0; cke_i = 1'b1;
      tick();
      chk("R10 oe off", cke_oe, 0);
      chk("R10 ack off", pd_ack, 0);
      chk("R10 ready off", cmd_ready, 0);
      cpu_rst_n = 1'b1;
      for (int i = 0; i < 3; i++) tick();
      chk("R10 still in window", cke_oe, 0);
      tick();
      chk("R10 oe back", cke_oe, 1);
      chk("R10 strap resampled", strap_q, 1);
      cke_i = 1'b0;
      tick();
      chk("R10 ready back", cmd_ready, 1);
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_window(4'b1111);
      t_reset_window(4'b0111);
      t_pd_closed();
      t_exit(3);
      t_pd_open();
      t_exit(0);
      t_reopen();
      t_exit(1);
      t_withdraw();
      t_cpu_reset_in_pd();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule